// File: doc/BRIEF.md
# Repeater Port Status Serial Scanner

This block sits beside a repeater core and reports the state of one attachment-unit (AUI) port and eight twisted-pair ports over a single serial output. While reset is held, a strap input chooses between the normal management mode and a minimal status mode. The level on the low select pin during reset sets the automatic receive polarity correction option. In minimal mode the block shifts out a 9-bit frame, one bit per strobe. Simple external logic can capture the frame into LED latches.

Two select pins are sampled at the start of each frame and pick one of four status groups. Three kinds of status are sticky event bits: bit rate errors, AUI loopback and AUI SQE test errors. Each of these stays set until its bit has been shifted out. In normal management mode the full command protocol is out of scope. A small stub answers only the version query command.

Top module: `port_status_scanner`

## Requirements
- R1: While `rst` is high, `min_mode` takes the level of `test_strap`. When reset is released, the value sampled on the last reset cycle selects minimal mode (1) or normal management mode (0).
- R2: `pol_corr_en` is 1 only in minimal mode, and only when `sel_lo` was 1 on the last reset cycle.
- R3: The select code {`sel_hi`,`sel_lo`} picks the frame contents:
  - 00: bit 0 is the sticky AUI SQE error, and bits 1..8 are `tp_pol_rev[0..7]`.
  - 01: bits 0..8 are the sticky `bre_evt[0..8]` flags, with index 0 the AUI.
  - 10: bit 0 is the sticky AUI loopback flag, and bits 1..8 are `tp_link[0..7]`.
  - 11: bits 0..8 are `part[0..8]`, with index 0 the AUI.
- R4: In minimal mode, each `stb` pulse moves one bit of the frame to `so` on the following clock, in bit order 0 (the AUI) to 8. After bit 8 the next frame begins.
- R5: The select code is sampled only on the strobe that sends bit 0. Changes on the select pins during the rest of the frame have no effect on that frame.
- R6: A sticky bit is set by its event input, stays set while no event and no scan-out occurs, and clears after the strobe that shifts it out.
- R7: An event that arrives on the same clock as the scan-out of its bit leaves that bit set.
- R8: After reset is released, `test_strap` has no effect. The mode changes only through another reset.
- R9: In normal mode, each strobe shifts `sel_lo` in as a command bit, MSB first. After the 8th bit, the command 0xFF makes the next 8 strobes send 0x01 on `so`, MSB first. During those 8 strobes `sel_lo` is ignored. Any other command gives no response, and `so` stays 0.
- R10: While `rst` is high, `so` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_strap | input | 1 | Mode strap, sampled during reset |
| sel_lo | input | 1 | Low select bit, polarity option strap, and command data in normal mode |
| sel_hi | input | 1 | High select bit |
| stb | input | 1 | One-clock pulse that marks the end of each strobe cycle |
| aui_sqe_evt | input | 1 | AUI SQE test error event |
| aui_lpbk_evt | input | 1 | AUI loopback event |
| bre_evt | input | 9 | Bit rate error events, index 0 is the AUI |
| tp_link | input | 8 | Twisted-pair link status levels |
| tp_pol_rev | input | 8 | Twisted-pair reversed receive polarity levels |
| part | input | 9 | Partition status levels, index 0 is the AUI |
| so | output | 1 | Registered serial status output |
| min_mode | output | 1 | Minimal status mode is active |
| pol_corr_en | output | 1 | Automatic receive polarity correction is enabled |

## Verification
The scan-out of a sticky bit and a new event for that same bit can fall on the same clock. The resulting clear and set must resolve so that the bit stays set. The bench provokes this by holding every event input high for whole frames, and then dropping them to watch the bits clear after the next scan. A behavioural model in the bench follows every clock. It also changes the select pins on every strobe in the middle of frames, to show that a frame keeps the code it sampled at its start.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [1:0] {
    GRP_POL  = 2'b00,
    GRP_BRE  = 2'b01,
    GRP_LINK = 2'b10,
    GRP_PART = 2'b11
  } grp_e;
endpackage

// File: rtl/rps_sticky.sv
module rps_sticky #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= (q_o & ~clr_i) | set_i;
  end

  // R7
  sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R6
  sticky_clr_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/rps_scan.sv
module rps_scan
  import rps_pkg::*;
#(
  parameter int FRAME = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             stb_i,
  input  logic [1:0]       sel_i,
  input  logic [FRAME-1:0] pol_grp_i,
  input  logic [FRAME-1:0] bre_grp_i,
  input  logic [FRAME-1:0] link_grp_i,
  input  logic [FRAME-1:0] part_grp_i,
  output logic             bit_o,
  output logic             clr_sqe_o,
  output logic             clr_lpbk_o,
  output logic [FRAME-1:0] clr_bre_o
);
  localparam int IDX_W = $clog2(FRAME);

  logic [IDX_W-1:0] idx_q;
  grp_e             sel_q;
  grp_e             sel_eff;
  logic             fire;
  logic [FRAME-1:0] grp_vec;

  assign fire    = en_i && stb_i;
  assign sel_eff = (idx_q == '0) ? grp_e'(sel_i) : sel_q;

  always_comb begin
    unique case (sel_eff)
      GRP_POL:  grp_vec = pol_grp_i;
      GRP_BRE:  grp_vec = bre_grp_i;
      GRP_LINK: grp_vec = link_grp_i;
      default:  grp_vec = part_grp_i;
    endcase
  end

  assign bit_o      = grp_vec[idx_q];
  assign clr_sqe_o  = fire && (sel_eff == GRP_POL)  && (idx_q == '0);
  assign clr_lpbk_o = fire && (sel_eff == GRP_LINK) && (idx_q == '0);

  for (genvar i = 0; i < FRAME; i++) begin : g_clr
    assign clr_bre_o[i] = fire && (sel_eff == GRP_BRE) && (idx_q == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      sel_q <= GRP_POL;
    end else if (fire) begin
      if (idx_q == '0) sel_q <= grp_e'(sel_i);
      idx_q <= (idx_q == IDX_W'(FRAME-1)) ? '0 : idx_q + 1'b1;
    end
  end

  // R4
  idx_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && idx_q == IDX_W'(FRAME-1)) |=> (idx_q == '0));

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx_q < IDX_W'(FRAME));

  // R5
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && idx_q != '0) |=> $stable(sel_q));
endmodule

// File: rtl/rps_verstub.sv
module rps_verstub #(
  parameter int         CMD_W = 8,
  parameter logic [7:0] QUERY = 8'hFF,
  parameter logic [7:0] REPLY = 8'h01
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic stb_i,
  input  logic din_i,
  output logic bit_o
);
  localparam int CNT_W = $clog2(CMD_W + 1);

  logic [CMD_W-1:0] cmd_q;
  logic [CMD_W-1:0] rsp_q;
  logic [CNT_W-1:0] rx_cnt_q;
  logic [CNT_W-1:0] tx_cnt_q;
  logic [CMD_W-1:0] cmd_nxt;

  assign cmd_nxt = {cmd_q[CMD_W-2:0], din_i};
  assign bit_o   = (tx_cnt_q != '0) ? rsp_q[CMD_W-1] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      rsp_q    <= '0;
      rx_cnt_q <= '0;
      tx_cnt_q <= '0;
    end else if (en_i && stb_i) begin
      if (tx_cnt_q != '0) begin
        rsp_q    <= {rsp_q[CMD_W-2:0], 1'b0};
        tx_cnt_q <= tx_cnt_q - 1'b1;
      end else begin
        cmd_q <= cmd_nxt;
        if (rx_cnt_q == CNT_W'(CMD_W-1)) begin
          rx_cnt_q <= '0;
          if (cmd_nxt == QUERY[CMD_W-1:0]) begin
            rsp_q    <= REPLY[CMD_W-1:0];
            tx_cnt_q <= CNT_W'(CMD_W);
          end
        end else begin
          rx_cnt_q <= rx_cnt_q + 1'b1;
        end
      end
    end
  end

  // R9
  rsp_count_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i && stb_i && tx_cnt_q != '0) |=> (tx_cnt_q == $past(tx_cnt_q) - 1'b1));

  // R9
  rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_cnt_q != '0) |-> (rx_cnt_q == '0));
endmodule

// File: rtl/port_status_scanner.sv
module port_status_scanner
  import rps_pkg::*;
#(
  parameter int NUM_TP = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              test_strap,
  input  logic              sel_lo,
  input  logic              sel_hi,
  input  logic              stb,
  input  logic              aui_sqe_evt,
  input  logic              aui_lpbk_evt,
  input  logic [NUM_TP:0]   bre_evt,
  input  logic [NUM_TP-1:0] tp_link,
  input  logic [NUM_TP-1:0] tp_pol_rev,
  input  logic [NUM_TP:0]   part,
  output logic              so,
  output logic              min_mode,
  output logic              pol_corr_en
);
  localparam int FRAME = NUM_TP + 1;

  logic             pol_opt_q;
  logic [1:0]       aui_q;
  logic [FRAME-1:0] bre_q;
  logic             scan_bit, ver_bit;
  logic             clr_sqe, clr_lpbk;
  logic [FRAME-1:0] clr_bre;

  always_ff @(posedge clk) begin
    if (rst) begin
      min_mode  <= test_strap;
      pol_opt_q <= sel_lo;
    end
  end

  assign pol_corr_en = min_mode && pol_opt_q;

  rps_sticky #(.N(2)) u_aui_sticky (
    .clk(clk), .rst(rst),
    .set_i({aui_lpbk_evt, aui_sqe_evt}),
    .clr_i({clr_lpbk, clr_sqe}),
    .q_o(aui_q)
  );

  rps_sticky #(.N(FRAME)) u_bre_sticky (
    .clk(clk), .rst(rst),
    .set_i(bre_evt), .clr_i(clr_bre), .q_o(bre_q)
  );

  rps_scan #(.FRAME(FRAME)) u_scan (
    .clk(clk), .rst(rst), .en_i(min_mode), .stb_i(stb),
    .sel_i({sel_hi, sel_lo}),
    .pol_grp_i({tp_pol_rev, aui_q[0]}),
    .bre_grp_i(bre_q),
    .link_grp_i({tp_link, aui_q[1]}),
    .part_grp_i(part),
    .bit_o(scan_bit),
    .clr_sqe_o(clr_sqe), .clr_lpbk_o(clr_lpbk), .clr_bre_o(clr_bre)
  );

  rps_verstub #(.CMD_W(8)) u_ver (
    .clk(clk), .rst(rst), .en_i(!min_mode), .stb_i(stb),
    .din_i(sel_lo), .bit_o(ver_bit)
  );

  always_ff @(posedge clk) begin
    if (rst)      so <= 1'b0;
    else if (stb) so <= min_mode ? scan_bit : ver_bit;
  end

  // R10
  so_rst_chk: assert property (@(posedge clk) rst |=> !so);

  // R1
  mode_strap_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (min_mode == $past(test_strap)));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(min_mode));

  // R2
  pol_mode_chk: assert property (@(posedge clk) disable iff (rst)
    pol_corr_en |-> min_mode);
endmodule

// File: tb/tb_port_status_scanner.sv
module tb_port_status_scanner;
  logic clk = 1'b0, rst = 1'b1, test_strap = 1'b0, sel_lo = 1'b0, sel_hi = 1'b0, stb = 1'b0;
  logic aui_sqe_evt = 1'b0, aui_lpbk_evt = 1'b0;
  logic [8:0] bre_evt = '0, part = '0;
  logic [7:0] tp_link = '0, tp_pol_rev = '0;
  logic so, min_mode, pol_corr_en;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string req = "R10";

  // reference state
  bit m_min, m_pol, m_so, m_sqe, m_lpbk;
  bit [8:0] m_bre;
  int m_idx, m_sel, m_ccnt;
  bit [7:0] m_cmd;
  bit rq[$];

  port_status_scanner dut (.*);

  always #5 clk = ~clk;

  function automatic bit grp_bit(int s, int i);
    case (s)
      0: return (i == 0) ? m_sqe : tp_pol_rev[i-1];
      1: return m_bre[i];
      2: return (i == 0) ? m_lpbk : tp_link[i-1];
      default: return part[i];
    endcase
  endfunction

  task automatic model_step();
    bit c_sqe = 0, c_lpbk = 0;
    bit [8:0] c_bre = '0;
    if (rst) begin
      m_min = test_strap; m_pol = sel_lo; m_so = 0; m_idx = 0; m_sel = 0;
      m_sqe = 0; m_lpbk = 0; m_bre = '0; m_cmd = '0; m_ccnt = 0; rq.delete();
      return;
    end
    if (stb) begin
      if (m_min) begin
        int s = (m_idx == 0) ? {sel_hi, sel_lo} : m_sel;
        if (m_idx == 0) m_sel = s;
        m_so = grp_bit(s, m_idx);
        if (s == 0 && m_idx == 0) c_sqe = 1;
        if (s == 2 && m_idx == 0) c_lpbk = 1;
        if (s == 1) c_bre[m_idx] = 1;
        m_idx = (m_idx + 1) % 9;
      end else if (rq.size() > 0) begin
        m_so = rq.pop_front();
      end else begin
        m_so = 0;
        m_cmd = {m_cmd[6:0], sel_lo};
        m_ccnt++;
        if (m_ccnt == 8) begin
          m_ccnt = 0;
          if (m_cmd == 8'hFF) for (int k = 7; k >= 0; k--) rq.push_back(k == 0);
        end
      end
    end
    m_sqe  = (m_sqe & ~c_sqe) | aui_sqe_evt;
    m_lpbk = (m_lpbk & ~c_lpbk) | aui_lpbk_evt;
    m_bre  = (m_bre & ~c_bre) | bre_evt;
  endtask

  task automatic check(string what, bit act, bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    #2;
    check("so", so, m_so);
    check("min_mode", min_mode, m_min);
    check("pol_corr_en", pol_corr_en, m_pol & m_min);
  endtask

  // mode: 0 quiet, 1 sparse events, 2 events every cycle, 3 select changes each strobe
  task automatic strobes(int n, int mode, bit [1:0] sel);
    for (int k = 0; k < n; k++) begin
      tp_link = 8'($urandom); tp_pol_rev = 8'($urandom); part = 9'($urandom);
      if (mode == 3) {sel_hi, sel_lo} = 2'($urandom); else {sel_hi, sel_lo} = sel;
      for (int c = 0; c < 3; c++) begin
        stb = (c == 0);
        if (mode == 2) begin
          aui_sqe_evt = 1; aui_lpbk_evt = 1; bre_evt = '1;
        end else if (mode == 1) begin
          aui_sqe_evt = ($urandom % 8) == 0; aui_lpbk_evt = ($urandom % 8) == 0;
          bre_evt = 9'($urandom) & 9'($urandom) & 9'($urandom);
        end else begin
          aui_sqe_evt = 0; aui_lpbk_evt = 0; bre_evt = '0;
        end
        cyc();
      end
    end
    stb = 0; aui_sqe_evt = 0; aui_lpbk_evt = 0; bre_evt = '0;
  endtask

  task automatic send_cmd(bit [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      sel_lo = b[k]; stb = 1; cyc(); stb = 0; cyc();
    end
  endtask

  task automatic do_reset(bit t, bit s);
    rst = 1; test_strap = t; sel_lo = s; stb = 0;
    repeat (3) cyc();
    rst = 0; test_strap = 0; sel_lo = 0;
    cyc();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    req = "R10"; do_reset(0, 0);
    req = "R9";  send_cmd(8'hFF); for (int k = 0; k < 10; k++) begin sel_lo = 1; stb = 1; cyc(); stb = 0; cyc(); end
    send_cmd(8'h7E); for (int k = 0; k < 8; k++) begin sel_lo = 0; stb = 1; cyc(); stb = 0; cyc(); end
    req = "R8";  test_strap = 1; repeat (6) cyc(); test_strap = 0;
    req = "R2";  do_reset(1, 0); strobes(9, 0, 2'b11);
    req = "R1";  do_reset(1, 1);
    req = "R3";  for (int s = 0; s < 4; s++) strobes(18, 1, 2'(s));
    req = "R4";  strobes(27, 1, 2'b11);
    req = "R5";  strobes(45, 3, 2'b00);
    req = "R7";  strobes(18, 2, 2'b01); strobes(18, 2, 2'b00); strobes(18, 2, 2'b10);
    req = "R6";  strobes(18, 0, 2'b01); strobes(18, 0, 2'b00); strobes(18, 0, 2'b10);
    req = "R8";  test_strap = 0; repeat (4) cyc();
    req = "R10"; rst = 1; repeat (2) cyc(); rst = 0; cyc();
    done = 1;
    finish_run();
  end
endmodule